// File: doc/BRIEF.md
# DMA Channel Address and Count Register File

This block keeps the programmable transfer state for four DMA channels: a 16-bit starting address, a 16-bit transfer length, a running progress counter and two page bytes for each channel. Software reaches the address and length registers one byte at a time through an 8-bit port. A single byte pointer, shared by every channel, decides whether an access handles the low or the high byte, and the pointer flips after each access. The control unit can clear the pointer with a one-cycle pulse. It also supplies the per-channel direction bit, which selects whether the address counts down.

Reads do not return the stored values. An address read returns the live transfer address, which is the reload address moved forward or back by the progress counter. A length read returns the part of the length that remains. Writing a high byte reloads the channel, so the next transfer starts from the newly written position with no progress. The SHIFT parameter scales both registers for controllers that move 16-bit words. For a channel picked by the transfer engine, the block also builds the 31-bit physical address from the two page bytes and the live address.

Top module: `dma_chan_regs`

## Requirements
- R1: On the channel port, sel[2:1] picks the channel and sel[0] picks the register: 0 for the address, 1 for the length. An access to one channel leaves the registers of every other channel as they were.
- R2: After reset the byte pointer is 0. Each cycle with a channel read or write flips it exactly once. An access made while the pointer is 0 handles bits 7:0, and one made while it is 1 handles bits 15:8.
- R3: A ptr_clr pulse forces the pointer to 0 in the next cycle. This holds even when a channel access in the same cycle would have flipped it. That access still uses the pointer value it saw.
- R4: A high-byte write to either register of a channel copies (base address << SHIFT) into that channel's current address and clears its progress counter. A low-byte write changes only the stored byte.
- R5: When mode_dec for the channel is 0, an address read returns byte ptr of ((current address + progress) >> SHIFT).
- R6: When mode_dec for the channel is 1, an address read returns byte ptr of ((current address − progress) >> SHIFT).
- R7: A length read returns byte ptr of (((base length << SHIFT) − progress) >> SHIFT).
- R8: A page access at offset off maps to a channel as follows: 1 to channel 2, 2 to channel 3, 3 to channel 1, 7 to channel 0. The page_hi input chooses the high page byte instead of the low one. A write to any other offset changes no page byte, and a read of such an offset returns 0.
- R9: phys_addr equals {high page[6:0], page[7:0], current address[15:0]} of the channel on phys_ch.
- R10: A cycle with adv_en adds 1 to the progress counter of channel adv_ch. If a reload of the same channel happens in that cycle, the reload wins.
- R11: After reset every base, current, progress and page value is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_wr | input | 1 | Channel port write strobe |
| chan_rd | input | 1 | Channel port read strobe |
| chan_sel | input | 3 | Channel port offset |
| chan_wdata | input | 8 | Channel port write byte |
| chan_rdata | output | 8 | Channel port read byte (valid in the cycle of chan_rd) |
| ptr_clr | input | 1 | Clear pulse for the byte pointer |
| mode_dec | input | 4 | Per-channel address decrement select |
| adv_en | input | 1 | Progress increment strobe |
| adv_ch | input | 2 | Channel whose progress advances |
| page_wr | input | 1 | Page write strobe |
| page_rd | input | 1 | Page read strobe |
| page_hi | input | 1 | Selects the high page byte |
| page_off | input | 3 | Page port offset |
| page_wdata | input | 8 | Page write byte |
| page_rdata | output | 8 | Page read byte |
| phys_ch | input | 2 | Channel whose physical address is shown |
| phys_addr | output | 31 | Physical transfer address |

## Verification
Assertions check the byte pointer on every cycle: it flips on an access, clears on the pulse with priority, and holds otherwise. They also check that a high-byte write zeroes progress and reloads the address, that progress advances by one, and that writes to unmapped page offsets leave every page byte unchanged. The numeric results of reads cannot be seen by a property. Only the bench scenarios show them: the sum and difference arithmetic for address reads in both directions, the remaining-length value, byte selection across sequences of accesses, the page offset map, and the assembled physical address.

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int SHIFT = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        chan_wr,
  input  logic        chan_rd,
  input  logic [2:0]  chan_sel,
  input  logic [7:0]  chan_wdata,
  output logic [7:0]  chan_rdata,
  input  logic        ptr_clr,
  input  logic [3:0]  mode_dec,
  input  logic        adv_en,
  input  logic [1:0]  adv_ch,
  input  logic        page_wr,
  input  logic        page_rd,
  input  logic        page_hi,
  input  logic [2:0]  page_off,
  input  logic [7:0]  page_wdata,
  output logic [7:0]  page_rdata,
  input  logic [1:0]  phys_ch,
  output logic [30:0] phys_addr
);

  localparam int NCH = 4;
  localparam int RW  = 16;
  localparam int CW  = RW + SHIFT;

  logic [NCH-1:0][RW-1:0] base_a, base_c;
  logic [NCH-1:0][CW-1:0] cur_a, prog;
  logic [NCH-1:0][7:0]    pg_lo, pg_hi;
  logic                   ptr_q;

  logic [1:0] ch;
  logic       is_cnt, access, reload;
  assign ch     = chan_sel[2:1];
  assign is_cnt = chan_sel[0];
  assign access = chan_wr | chan_rd;
  assign reload = chan_wr & ptr_q;

  logic [RW-1:0] new_base_a;
  always_comb begin
    new_base_a = base_a[ch];
    if (!is_cnt) new_base_a = {chan_wdata, base_a[ch][7:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_q <= 1'b0;
    else if (ptr_clr) ptr_q <= 1'b0;
    else if (access) ptr_q <= ~ptr_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_a <= '0;
      base_c <= '0;
      cur_a  <= '0;
      prog   <= '0;
    end else begin
      if (adv_en) prog[adv_ch] <= prog[adv_ch] + CW'(1);
      if (chan_wr) begin
        if (!ptr_q) begin
          if (is_cnt) base_c[ch][7:0] <= chan_wdata;
          else        base_a[ch][7:0] <= chan_wdata;
        end else begin
          if (is_cnt) base_c[ch][15:8] <= chan_wdata;
          else        base_a[ch][15:8] <= chan_wdata;
          cur_a[ch] <= CW'(new_base_a) << SHIFT;
          prog[ch]  <= '0;
        end
      end
    end
  end

  logic [CW-1:0] rd_full;
  logic [RW-1:0] rd_word;
  always_comb begin
    if (is_cnt)          rd_full = (CW'(base_c[ch]) << SHIFT) - prog[ch];
    else if (mode_dec[ch]) rd_full = cur_a[ch] - prog[ch];
    else                 rd_full = cur_a[ch] + prog[ch];
    rd_word = RW'(rd_full >> SHIFT);
  end
  assign chan_rdata = !chan_rd ? 8'h00 : (ptr_q ? rd_word[15:8] : rd_word[7:0]);

  logic       pmap_ok;
  logic [1:0] pmap_ch;
  always_comb begin
    pmap_ok = 1'b1;
    pmap_ch = 2'd0;
    case (page_off)
      3'd1:    pmap_ch = 2'd2;
      3'd2:    pmap_ch = 2'd3;
      3'd3:    pmap_ch = 2'd1;
      3'd7:    pmap_ch = 2'd0;
      default: pmap_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pg_lo <= '0;
      pg_hi <= '0;
    end else if (page_wr && pmap_ok) begin
      if (page_hi) pg_hi[pmap_ch] <= page_wdata;
      else         pg_lo[pmap_ch] <= page_wdata;
    end
  end

  assign page_rdata = !(page_rd && pmap_ok) ? 8'h00 :
                      (page_hi ? pg_hi[pmap_ch] : pg_lo[pmap_ch]);

  assign phys_addr = {pg_hi[phys_ch][6:0], pg_lo[phys_ch], cur_a[phys_ch][15:0]};

  AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_clr |=> !ptr_q); // R3
  AST_PTR_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (access && !ptr_clr) |=> (ptr_q != $past(ptr_q))); // R2
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!access && !ptr_clr) |=> $stable(ptr_q)); // R2
  AST_RELOAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (prog[$past(ch)] == '0)); // R4
  AST_RELOAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (cur_a[$past(ch)] == (CW'(base_a[$past(ch)]) << SHIFT))); // R4
  AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_en && !(reload && ch == adv_ch)) |=>
      (prog[$past(adv_ch)] == $past(prog[adv_ch]) + CW'(1))); // R10
  AST_PAGE_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (page_wr && !pmap_ok) |=> ($stable(pg_lo) && $stable(pg_hi))); // R8

endmodule

// File: tb/tb_dma_chan_regs.sv
module tb_dma_chan_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;
  // vector: {wr, rd, sel[2:0], data[7:0], exp[7:0]}
  localparam logic [20:0] VEC [NVEC] = '{
    {1'b1,1'b0,3'd0,8'h34,8'h00}, {1'b1,1'b0,3'd0,8'h12,8'h00},
    {1'b1,1'b0,3'd1,8'h05,8'h00}, {1'b1,1'b0,3'd1,8'h00,8'h00},
    {1'b0,1'b1,3'd0,8'h00,8'h34}, {1'b0,1'b1,3'd0,8'h00,8'h12},
    {1'b0,1'b1,3'd1,8'h00,8'h05}, {1'b0,1'b1,3'd1,8'h00,8'h00},
    {1'b1,1'b0,3'd6,8'hCD,8'h00}, {1'b1,1'b0,3'd6,8'hAB,8'h00},
    {1'b0,1'b1,3'd7,8'h00,8'h00}, {1'b0,1'b1,3'd7,8'h00,8'h00},
    {1'b0,1'b1,3'd6,8'h00,8'hCD}, {1'b0,1'b1,3'd6,8'h00,8'hAB},
    {1'b0,1'b1,3'd0,8'h00,8'h34}, {1'b0,1'b1,3'd0,8'h00,8'h12}
  };

  logic clk = 0, rst_n = 0;
  logic chan_wr = 0, chan_rd = 0, ptr_clr = 0, adv_en = 0;
  logic page_wr = 0, page_rd = 0, page_hi = 0;
  logic [2:0] chan_sel = 0, page_off = 0;
  logic [7:0] chan_wdata = 0, page_wdata = 0, chan_rdata, page_rdata;
  logic [3:0] mode_dec = 0;
  logic [1:0] adv_ch = 0, phys_ch = 0;
  logic [30:0] phys_addr;
  int total = 0, bad = 0;
  bit finished = 0;

  dma_chan_regs dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chan_op(input logic wr, input logic rd, input logic [2:0] sel,
                         input logic [7:0] d, input logic clr, output logic [7:0] q);
    @(negedge clk);
    chan_wr = wr; chan_rd = rd; chan_sel = sel; chan_wdata = d; ptr_clr = clr;
    #1 q = chan_rdata;
    @(posedge clk); #1;
    chan_wr = 0; chan_rd = 0; ptr_clr = 0;
  endtask

  task automatic advance(input logic [1:0] c);
    @(negedge clk); adv_en = 1; adv_ch = c;
    @(posedge clk); #1 adv_en = 0;
  endtask

  task automatic page_op(input logic wr, input logic hi, input logic [2:0] off,
                         input logic [7:0] d, output logic [7:0] q);
    @(negedge clk);
    page_wr = wr; page_rd = ~wr; page_hi = hi; page_off = off; page_wdata = d;
    #1 q = page_rdata;
    @(posedge clk); #1;
    page_wr = 0; page_rd = 0;
  endtask

  initial begin
    repeat (400) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] q;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R11 phys after reset", phys_addr, 31'h0);
    chan_op(0, 1, 3'd0, 0, 0, q); chk("R11 addr low after reset", q, 8'h00);
    chan_op(0, 1, 3'd0, 0, 0, q); chk("R2 R11 addr high after reset", q, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      chan_op(VEC[i][20], VEC[i][19], VEC[i][18:16], VEC[i][15:8], 0, q);
      if (VEC[i][19]) chk("R1 R2 R4 R7 vector read", q, VEC[i][7:0]);
    end

    repeat (3) advance(2'd0);
    chan_op(0, 1, 3'd0, 0, 0, q); chk("R5 addr+progress low", q, 8'h37);
    chan_op(0, 1, 3'd0, 0, 0, q); chk("R5 addr+progress high", q, 8'h12);
    chan_op(0, 1, 3'd1, 0, 0, q); chk("R7 remaining low", q, 8'h02);
    chan_op(0, 1, 3'd1, 0, 0, q); chk("R7 remaining high", q, 8'h00);
    chan_op(0, 1, 3'd6, 0, 0, q); chk("R10 other channel untouched", q, 8'hCD);
    chan_op(0, 1, 3'd6, 0, 0, q);
    mode_dec = 4'b0001;
    chan_op(0, 1, 3'd0, 0, 0, q); chk("R6 addr-progress low", q, 8'h31);
    chan_op(0, 1, 3'd0, 0, 0, q); chk("R6 addr-progress high", q, 8'h12);
    mode_dec = 4'b0000;

    chan_op(0, 1, 3'd0, 0, 0, q);
    chan_op(0, 1, 3'd0, 0, 1, q); chk("R3 access with clear sees high", q, 8'h12);
    chan_op(0, 1, 3'd0, 0, 0, q); chk("R3 clear wins over toggle", q, 8'h37);
    chan_op(0, 0, 3'd0, 0, 1, q);

    chan_op(1, 0, 3'd0, 8'h99, 0, q);
    chan_op(0, 0, 3'd0, 0, 1, q);
    chan_op(0, 1, 3'd1, 0, 0, q); chk("R4 low write keeps progress", q, 8'h02);
    chan_op(0, 0, 3'd0, 0, 1, q);
    @(negedge clk); phys_ch = 0;
    chk("R4 low write keeps current address", phys_addr[15:0], 16'h1234);

    chan_op(1, 0, 3'd1, 8'h05, 0, q);
    chan_op(1, 0, 3'd1, 8'h00, 0, q);
    chan_op(0, 1, 3'd1, 0, 0, q); chk("R4 high write clears progress", q, 8'h05);
    chan_op(0, 1, 3'd1, 0, 0, q);
    chan_op(0, 1, 3'd0, 0, 0, q); chk("R4 reload uses new base", q, 8'h99);

    page_op(1, 0, 3'd7, 8'h56, q);
    page_op(1, 1, 3'd7, 8'hFF, q);
    page_op(1, 0, 3'd0, 8'hEE, q);
    page_op(1, 1, 3'd4, 8'hEE, q);
    page_op(0, 0, 3'd0, 0, q); chk("R8 unmapped read zero", q, 8'h00);
    page_op(0, 0, 3'd7, 0, q); chk("R8 offset 7 to channel 0", q, 8'h56);
    page_op(0, 1, 3'd7, 0, q); chk("R8 high page read", q, 8'hFF);
    page_op(0, 0, 3'd1, 0, q); chk("R8 unmapped write ignored", q, 8'h00);
    page_op(1, 0, 3'd1, 8'h22, q);
    page_op(1, 0, 3'd3, 8'h33, q);
    @(negedge clk); phys_ch = 0;
    chk("R9 phys channel 0", phys_addr, {7'h7F, 8'h56, 16'h1299});
    phys_ch = 2; #1;
    chk("R9 R8 phys channel 2 via offset 1", phys_addr, {7'h00, 8'h22, 16'h0000});
    phys_ch = 1; #1;
    chk("R8 offset 3 to channel 1", phys_addr, {7'h00, 8'h33, 16'h0000});
    phys_ch = 3; #1;
    chk("R9 R1 phys channel 3", phys_addr, {7'h00, 8'h00, 16'hABCD});

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule